// File: doc/BRIEF.md
# Suspend and Wake-up Controller

This block parks a small microcontroller in a low-power suspend state and later returns it to execution. Software enters suspend with a single write to the processor control register that sets a suspend request bit. The same write carries a resume-permit bit. On entry the block drops the enables of the main oscillator, the free-running timer and the watchdog timer, and it holds the CPU. It runs on an always-on wake-up clock. While suspended it watches four wake sources: GPIO interrupts that are both pending and enabled, a wake-up timer interrupt, an SPI slave interrupt, and a low level on the USB D- line. The D- line is first brought through a two-flop synchronizer.

When a wake source is seen, the oscillator is re-enabled. The block then waits for the oscillator to report that it is stable, and after that counts a resume delay. The length of that delay depends on the clock source chosen for wake-up: internal, external with the short delay, or external with the long delay. The CPU is then released. An interrupt-block output holds off interrupt service until the CPU has retired one instruction, so the instruction after the suspend write runs first.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After reset, `cpu_run`, `osc_en`, `ftimer_en` and `wdog_en` are 1, and `suspended` and `irq_block` are 0.
- R2: A cycle with `ctl_wr`=1 and `ctl_suspend`=1 in run makes `osc_en`, `ftimer_en`, `wdog_en` and `cpu_run` 0 and `suspended` 1 from the next cycle. A write with `ctl_suspend`=0 has no effect.
- R3: In suspend, each of these wakes the block on its own: a GPIO bit i with `gpio_pend[i]`=1 and `gpio_en[i]`=1, `timer_wake`=1, `spi_wake`=1, or `dminus_n`=0. A pending GPIO bit whose enable is 0 does not wake it.
- R4: The level of `irq_sense` has no effect on wake-up or on its timing.
- R5: If a wake source is already active when suspend is written, the block still passes through suspend. With `osc_stable` held at 1, `cpu_run` returns to 1 on the (N+4)th rising edge, counting the edge that captures the write. N is the selected delay.
- R6: After a wake, `osc_en` is 1 while `cpu_run` stays 0 for as long as `osc_stable` is 0. Once `osc_stable` is 1, `cpu_run` returns to 1 after N+1 rising edges.
- R7: The delay N is selected at resume from two inputs. `ext_osc_sel`=0 gives INT_DLY. `ext_osc_sel`=1 with `ext_slow_resume`=0 gives EXT_DLY_S. `ext_osc_sel`=1 with `ext_slow_resume`=1 gives EXT_DLY_L.
- R8: If the suspend write has `ctl_run`=0, the block never leaves suspend until reset, whatever the wake sources do.
- R9: `irq_block` is 1 from the cycle `cpu_run` returns to 1 after a wake. It clears on the cycle after the first `instr_retire` pulse.
- R10: `ftimer_en` and `wdog_en` stay 0 until `cpu_run` is 1 again, through the oscillator wait and the resume delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on wake-up clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_suspend | input | 1 | Suspend request bit of the write |
| ctl_run | input | 1 | Resume-permit bit of the write |
| irq_sense | input | 1 | Interrupt enable sense bit (ignored for wake-up) |
| ext_osc_sel | input | 1 | Wake-up clock source: 1 selects external |
| ext_slow_resume | input | 1 | Long resume delay when external clock is selected |
| gpio_pend | input | GPIO_W | Pending GPIO interrupts |
| gpio_en | input | GPIO_W | GPIO interrupt enables |
| timer_wake | input | 1 | Enabled wake-up timer interrupt |
| spi_wake | input | 1 | Enabled SPI slave interrupt |
| dminus_n | input | 1 | Asynchronous USB D- level, low means bus activity |
| osc_stable | input | 1 | Oscillator stable indication |
| instr_retire | input | 1 | CPU retired one instruction |
| osc_en | output | 1 | Main oscillator enable |
| ftimer_en | output | 1 | Free-running timer clock enable |
| wdog_en | output | 1 | Watchdog clock enable |
| cpu_run | output | 1 | CPU released |
| irq_block | output | 1 | Hold off interrupt service |
| suspended | output | 1 | Block is entering or in suspend |

## Verification
The bench builds the block with GPIO_W=4 and delays of 3, 5 and 9 cycles. With these values it can sweep every combination of the three delay selections, each of the seven wake sources and both levels of the sense bit, and it checks the exact release cycle of each one. The short delays also make room for the slower cases. These are a wake that arrives late while the oscillator is held unstable, a pending GPIO bit whose enable is clear, and a suspend written without the resume permit.

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl #(
  parameter int GPIO_W    = 8,
  parameter int INT_DLY   = 8,
  parameter int EXT_DLY_S = 32,
  parameter int EXT_DLY_L = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_suspend,
  input  logic              ctl_run,
  input  logic              irq_sense,
  input  logic              ext_osc_sel,
  input  logic              ext_slow_resume,
  input  logic [GPIO_W-1:0] gpio_pend,
  input  logic [GPIO_W-1:0] gpio_en,
  input  logic              timer_wake,
  input  logic              spi_wake,
  input  logic              dminus_n,
  input  logic              osc_stable,
  input  logic              instr_retire,
  output logic              osc_en,
  output logic              ftimer_en,
  output logic              wdog_en,
  output logic              cpu_run,
  output logic              irq_block,
  output logic              suspended
);
  localparam int MAXD  = (INT_DLY > EXT_DLY_S) ? ((INT_DLY > EXT_DLY_L) ? INT_DLY : EXT_DLY_L)
                                               : ((EXT_DLY_S > EXT_DLY_L) ? EXT_DLY_S : EXT_DLY_L);
  localparam int CNT_W = $clog2(MAXD + 1);

  typedef enum logic [2:0] {S_RUN, S_ENTER, S_SUSP, S_OSCW, S_DLY} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             run_ok;
  logic             dm_s1, dm_s2;
  logic             wake;
  logic [CNT_W-1:0] dly_load;
  logic             sense_unused;

  assign sense_unused = irq_sense;
  assign wake = (|(gpio_pend & gpio_en)) | timer_wake | spi_wake | ~dm_s2;

  always_comb begin
    if (!ext_osc_sel)          dly_load = CNT_W'(INT_DLY - 1);
    else if (!ext_slow_resume) dly_load = CNT_W'(EXT_DLY_S - 1);
    else                       dly_load = CNT_W'(EXT_DLY_L - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_s1 <= 1'b1;
      dm_s2 <= 1'b1;
    end else begin
      dm_s1 <= dminus_n;
      dm_s2 <= dm_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      cnt       <= '0;
      run_ok    <= 1'b1;
      irq_block <= 1'b0;
    end else begin
      case (st)
        S_RUN: begin
          if (instr_retire) irq_block <= 1'b0;
          if (ctl_wr && ctl_suspend) begin
            st     <= S_ENTER;
            run_ok <= ctl_run;
          end
        end
        S_ENTER: st <= S_SUSP;
        S_SUSP:  if (run_ok && wake) st <= S_OSCW;
        S_OSCW: if (osc_stable) begin
          st  <= S_DLY;
          cnt <= dly_load;
        end
        S_DLY: begin
          if (cnt == '0) begin
            st        <= S_RUN;
            irq_block <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign cpu_run   = (st == S_RUN);
  assign suspended = (st == S_ENTER) || (st == S_SUSP);
  assign osc_en    = !suspended;
  assign ftimer_en = cpu_run;
  assign wdog_en   = cpu_run;
endmodule

// File: rtl/susp_wake_ctrl_chk.sv
module susp_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic ctl_suspend,
  input logic osc_en,
  input logic ftimer_en,
  input logic wdog_en,
  input logic cpu_run,
  input logic irq_block,
  input logic suspended
);
  assert_clocks_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!osc_en && !ftimer_en && !wdog_en && !cpu_run));

  assert_enter_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && ctl_wr && ctl_suspend) |=> (suspended && !osc_en));

  assert_timers_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ftimer_en || wdog_en) |-> cpu_run);

  assert_osc_before_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> osc_en);

  assert_block_on_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> irq_block);

  assert_block_only_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_block) |-> cpu_run);
endmodule

bind susp_wake_ctrl susp_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_suspend(ctl_suspend),
  .osc_en(osc_en), .ftimer_en(ftimer_en), .wdog_en(wdog_en),
  .cpu_run(cpu_run), .irq_block(irq_block), .suspended(suspended)
);

// File: tb/tb_susp_wake_ctrl.sv
`timescale 1ns/1ps
module tb_susp_wake_ctrl;
  localparam int GW = 4;
  localparam int DI = 3, DS = 5, DL = 9;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_suspend = 0, ctl_run = 0, irq_sense = 0;
  logic ext_osc_sel = 0, ext_slow_resume = 0;
  logic [GW-1:0] gpio_pend = '0, gpio_en = '0;
  logic timer_wake = 0, spi_wake = 0, dminus_n = 1, osc_stable = 1, instr_retire = 0;
  logic osc_en, ftimer_en, wdog_en, cpu_run, irq_block, suspended;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  susp_wake_ctrl #(.GPIO_W(GW), .INT_DLY(DI), .EXT_DLY_S(DS), .EXT_DLY_L(DL)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_suspend(ctl_suspend), .ctl_run(ctl_run),
    .irq_sense(irq_sense), .ext_osc_sel(ext_osc_sel), .ext_slow_resume(ext_slow_resume),
    .gpio_pend(gpio_pend), .gpio_en(gpio_en), .timer_wake(timer_wake), .spi_wake(spi_wake),
    .dminus_n(dminus_n), .osc_stable(osc_stable), .instr_retire(instr_retire),
    .osc_en(osc_en), .ftimer_en(ftimer_en), .wdog_en(wdog_en), .cpu_run(cpu_run),
    .irq_block(irq_block), .suspended(suspended));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic r);
    ctl_wr = 1; ctl_suspend = s; ctl_run = r;
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic clear_src();
    gpio_pend = '0; gpio_en = '0; timer_wake = 0; spi_wake = 0; dminus_n = 1;
  endtask

  function automatic int sel_dly(input int m);
    return (m == 0) ? DI : ((m == 1) ? DS : DL);
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cpu_run", cpu_run, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 timers", {ftimer_en, wdog_en}, 3);
    chk("R1 suspended", suspended, 0);
    chk("R1 irq_block", irq_block, 0);

    // R2 write without suspend bit has no effect
    wr(0, 1);
    chk("R2 no-suspend cpu_run", cpu_run, 1);
    chk("R2 no-suspend osc_en", osc_en, 1);

    // R5/R3/R4/R7 sweep with wake source already active at the write
    for (int m = 0; m < 3; m++) begin
      for (int src = 0; src < 7; src++) begin
        for (int sn = 0; sn < 2; sn++) begin
          int c;
          int n;
          n = sel_dly(m);
          ext_osc_sel = (m != 0);
          ext_slow_resume = (m == 2);
          irq_sense = sn[0];
          if (src < GW) begin
            gpio_pend[src] = 1; gpio_en[src] = 1;
          end else if (src == GW) timer_wake = 1;
          else if (src == GW + 1) spi_wake = 1;
          else dminus_n = 0;
          ctl_wr = 1; ctl_suspend = 1; ctl_run = 1;
          @(posedge clk);
          @(negedge clk);
          ctl_wr = 0;
          c = 1;
          chk("R2 gated on entry", {osc_en, ftimer_en, wdog_en, cpu_run, suspended}, 1);
          while (!cpu_run && c < 40) begin
            @(posedge clk);
            @(negedge clk);
            c++;
            if (!cpu_run) chk("R10 timers off", {ftimer_en, wdog_en}, 0);
          end
          chk($sformatf("R5 R7 R3 R4 release m=%0d src=%0d sense=%0d", m, src, sn), c, n + 4);
          chk("R9 block set", irq_block, 1);
          clear_src();
          @(negedge clk);
          chk("R9 block held", irq_block, 1);
          instr_retire = 1;
          @(negedge clk);
          instr_retire = 0;
          chk("R9 block cleared", irq_block, 0);
        end
      end
    end

    // R3 masked GPIO, R6 oscillator wait, late wake
    ext_osc_sel = 1; ext_slow_resume = 1; irq_sense = 0;
    osc_stable = 0;
    wr(1, 1);
    gpio_pend = 4'b0110;
    repeat (20) @(negedge clk);
    chk("R3 masked gpio stays suspended", suspended, 1);
    chk("R3 masked gpio cpu held", cpu_run, 0);
    gpio_en = 4'b0100;
    @(negedge clk);
    chk("R6 osc enabled after wake", osc_en, 1);
    repeat (10) @(negedge clk);
    chk("R6 cpu held while unstable", cpu_run, 0);
    chk("R10 timers off during osc wait", {ftimer_en, wdog_en}, 0);
    osc_stable = 1;
    begin
      int c = 0;
      while (!cpu_run && c < 40) begin
        @(posedge clk);
        @(negedge clk);
        c++;
      end
      chk("R6 R7 release after stable", c, DL + 1);
    end
    clear_src();
    instr_retire = 1;
    @(negedge clk);
    instr_retire = 0;
    chk("R9 block cleared late", irq_block, 0);

    // R8 resume permit clear
    timer_wake = 1;
    dminus_n = 0;
    wr(1, 0);
    repeat (40) @(negedge clk);
    chk("R8 no resume cpu_run", cpu_run, 0);
    chk("R8 no resume osc_en", osc_en, 0);
    clear_src();
    do_reset();
    chk("R1 after second reset", cpu_run, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule